// File: doc/BRIEF.md
# ADPCM Speech Decoder Core

This core turns a stream of 4-bit adaptive differential code words into signed samples for a 10-bit digital-to-analogue converter. It reads code words from a byte-wide read-only memory, two per byte, and runs an adaptive step size. It forms a prediction from the last output and adds the scaled code word to that prediction. The core then holds the result on the converter port until the next sample is ready.

Each sample needs two products: the new step size and the quantised difference. Both run one after the other on a single sequential radix-2 Booth multiplier of two's-complement numbers. A Moore controller steps through the load, wait and update phases. The controller then counts idle clocks, so each sample takes the same number of clocks (`SAMPLE_CLKS`). The memory is read combinationally from the address the core presents.

Top module: `adpcm_dec`

## Requirements
- R1: While `rst_ni` is low, `dac_o` is 0, `sample_valid_o` is 0 and `mem_addr_o` is 0. After reset is released, decoding restarts from the high nibble of address 0 with step size `STEP_INIT` (16) and a previous output of 0.
- R2: A code word is a 4-bit sign-magnitude value. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. The high nibble of a byte (bits 7:4) is decoded before the low nibble (bits 3:0). `mem_addr_o` advances by one only in the cycle the low nibble's sample appears, and it goes from `MEM_DEPTH-1` back to 0.
- R3: The prediction is the previous output minus that output shifted arithmetically right by three bits.
- R4: The new step size is floor(F·step/4). F depends on the magnitude: magnitudes 0 to 3 give 3, 4 gives 4, 5 gives 6, 6 gives 8 and 7 gives 10.
- R5: The step size is clamped to the range 1 to 2^(STEP_W-1)-1 (2047), so it never reaches zero and never wraps.
- R6: The new output is prediction plus (signed code word × new step size), saturated to the range -512 to 511 and presented in two's complement on `dac_o`.
- R7: `sample_valid_o` is high for exactly one clock in the cycle a new output first appears on `dac_o`, and `dac_o` holds its value in every other cycle.
- R8: Successive `sample_valid_o` pulses are exactly `SAMPLE_CLKS` (64) clocks apart.
- R9: Negative code words give negative differences through the shared multiplier. A run of large negative codes drives the output to -512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | ADDR_W | Byte address to the code memory |
| mem_data_i | input | 8 | Code byte read from `mem_addr_o` |
| dac_o | output | DAC_W | Decoded sample, two's complement |
| sample_valid_o | output | 1 | One-clock strobe when `dac_o` takes a new value |

## Verification
The low-nibble sample is the critical case. In that one update cycle the output register loads a new value, the strobe rises and the address advances to the next byte. The code memory is given 16 bytes and decoding runs past its end, so the address wraps in the same cycle as an output update. Each such cycle is then checked three ways: the output against an independent model, the address against the expected byte index, and the strobe spacing.

The byte contents also make the step clamps and the output saturation fall on the same sample. The model's values for those samples show whether both limits took effect together.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

  typedef enum logic [2:0] {
    ST_LOAD1, ST_WAIT1, ST_UPD1, ST_LOAD2, ST_WAIT2, ST_UPD2, ST_IDLE
  } ctrl_st_e;

  typedef struct packed {
    logic mul_start;  // launch a product
    logic mul_sel;    // 0: step product, 1: difference product
    logic ld_code;    // latch the current nibble
    logic ld_step;    // register new step size
    logic ld_out;     // register new output, advance nibble
  } ctrl_s;

  // step multiplier, two fractional bits
  function automatic logic [3:0] step_mult_q2(input logic [2:0] mag);
    logic [3:0] f;
    unique case (mag)
      3'd4:    f = 4'd4;
      3'd5:    f = 4'd6;
      3'd6:    f = 4'd8;
      3'd7:    f = 4'd10;
      default: f = 4'd3;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/adpcm_booth_mul.sv
module adpcm_booth_mul #(
  parameter int W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]   mcand_q;
  logic [2*W:0]   acc_q;     // {A, Q, q_-1}
  logic [2*W:0]   acc_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic           run_q;
  logic [W-1:0]   a_cur, a_sum;

  assign a_cur = acc_q[2*W:W+1];

  always_comb begin
    unique case (acc_q[1:0])
      2'b01:   a_sum = a_cur + mcand_q;
      2'b10:   a_sum = a_cur - mcand_q;
      default: a_sum = a_cur;
    endcase
    acc_nxt = {a_sum[W-1], a_sum, acc_q[W:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else if (start_i) begin
      mcand_q <= mcand_i;
      acc_q   <= {{W{1'b0}}, mplier_i, 1'b0};
      cnt_q   <= CNT_W'(W);
      run_q   <= 1'b1;
    end else if (run_q) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign done_o = !run_q;
  assign prod_o = acc_q[2*W:1];

endmodule

// File: rtl/adpcm_ctrl.sv
module adpcm_ctrl
  import adpcm_pkg::*;
#(
  parameter int MUL_W       = 12,
  parameter int SAMPLE_CLKS = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mul_done_i,
  output ctrl_s ctrl_o
);

  localparam int BUSY_CLKS = 2 * MUL_W + 6;
  localparam int IDLE_CLKS = SAMPLE_CLKS - BUSY_CLKS;
  localparam int IW        = $clog2(IDLE_CLKS + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CLKS - 1);

  initial begin
    if (IDLE_CLKS < 1) $error("SAMPLE_CLKS too small for MUL_W");
  end

  ctrl_st_e st_q, st_d;
  logic [IW-1:0] idle_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOAD1: st_d = ST_WAIT1;
      ST_WAIT1: if (mul_done_i) st_d = ST_UPD1;
      ST_UPD1:  st_d = ST_LOAD2;
      ST_LOAD2: st_d = ST_WAIT2;
      ST_WAIT2: if (mul_done_i) st_d = ST_UPD2;
      ST_UPD2:  st_d = ST_IDLE;
      ST_IDLE:  if (idle_q == IDLE_LAST) st_d = ST_LOAD1;
      default:  st_d = ST_LOAD1;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_LOAD1: ctrl_o = '{mul_start: 1'b1, mul_sel: 1'b0, ld_code: 1'b1, ld_step: 1'b0, ld_out: 1'b0};
      ST_WAIT1: ctrl_o = '{mul_start: 1'b0, mul_sel: 1'b0, ld_code: 1'b0, ld_step: 1'b0, ld_out: 1'b0};
      ST_UPD1:  ctrl_o = '{mul_start: 1'b0, mul_sel: 1'b0, ld_code: 1'b0, ld_step: 1'b1, ld_out: 1'b0};
      ST_LOAD2: ctrl_o = '{mul_start: 1'b1, mul_sel: 1'b1, ld_code: 1'b0, ld_step: 1'b0, ld_out: 1'b0};
      ST_WAIT2: ctrl_o = '{mul_start: 1'b0, mul_sel: 1'b1, ld_code: 1'b0, ld_step: 1'b0, ld_out: 1'b0};
      ST_UPD2:  ctrl_o = '{mul_start: 1'b0, mul_sel: 1'b1, ld_code: 1'b0, ld_step: 1'b0, ld_out: 1'b1};
      default:  ctrl_o = '{mul_start: 1'b0, mul_sel: 1'b0, ld_code: 1'b0, ld_step: 1'b0, ld_out: 1'b0};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LOAD1;
      idle_q <= '0;
    end else begin
      st_q   <= st_d;
      idle_q <= (st_q == ST_IDLE) ? idle_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/adpcm_datapath.sv
module adpcm_datapath
  import adpcm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MEM_DEPTH = 16,
  parameter int STEP_W    = 12,
  parameter int Y_W       = 10,
  parameter int STEP_INIT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_s               ctrl_i,
  input  logic [7:0]          mem_data_i,
  input  logic [2*STEP_W-1:0] mul_prod_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [STEP_W-1:0]   mul_a_o,
  output logic [STEP_W-1:0]   mul_b_o,
  output logic [Y_W-1:0]      dac_o,
  output logic                valid_o
);

  localparam int SCL_W = 2 * STEP_W - 2;
  localparam int SUM_W = 2 * STEP_W + 1;
  localparam logic [SCL_W-1:0] STEP_MAX = SCL_W'(2 ** (STEP_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] Y_HI = SUM_W'(2 ** (Y_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] Y_LO = SUM_W'(-(2 ** (Y_W - 1)));
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(MEM_DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              nib_q;
  logic [3:0]        code_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic signed [Y_W-1:0] y_q, y_d, pred;
  logic              valid_q;
  logic [3:0]        nib_cur;
  logic [STEP_W-1:0] mag_ext, code_sx;
  logic [SCL_W-1:0]  scaled;
  logic signed [SUM_W-1:0] sum;

  assign nib_cur = nib_q ? mem_data_i[3:0] : mem_data_i[7:4];

  // signed code word for the difference product
  assign mag_ext = STEP_W'(code_q[2:0]);
  assign code_sx = code_q[3] ? (~mag_ext + 1'b1) : mag_ext;

  assign mul_a_o = step_q;
  assign mul_b_o = ctrl_i.mul_sel ? code_sx : STEP_W'(step_mult_q2(nib_cur[2:0]));

  // step: drop two fractional bits, clamp to [1, max]
  assign scaled = mul_prod_i[2*STEP_W-1:2];
  always_comb begin
    if (scaled == '0)          step_d = STEP_W'(1);
    else if (scaled > STEP_MAX) step_d = STEP_MAX[STEP_W-1:0];
    else                        step_d = scaled[STEP_W-1:0];
  end

  // output: 7/8 prediction plus difference, saturated
  assign pred = y_q - (y_q >>> 3);
  assign sum  = SUM_W'(pred) + SUM_W'($signed(mul_prod_i));
  always_comb begin
    if (sum > Y_HI)      y_d = Y_HI[Y_W-1:0];
    else if (sum < Y_LO) y_d = Y_LO[Y_W-1:0];
    else                 y_d = sum[Y_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      nib_q   <= 1'b0;
      code_q  <= '0;
      step_q  <= STEP_W'(STEP_INIT);
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ctrl_i.ld_out;
      if (ctrl_i.ld_code) code_q <= nib_cur;
      if (ctrl_i.ld_step) step_q <= step_d;
      if (ctrl_i.ld_out) begin
        y_q   <= y_d;
        nib_q <= ~nib_q;
        if (nib_q) addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
      end
    end
  end

  assign mem_addr_o = addr_q;
  assign dac_o      = y_q;
  assign valid_o    = valid_q;

endmodule

// File: rtl/adpcm_dec.sv
module adpcm_dec
  import adpcm_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int MEM_DEPTH   = 16,
  parameter int STEP_W      = 12,
  parameter int DAC_W       = 10,
  parameter int STEP_INIT   = 16,
  parameter int SAMPLE_CLKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [DAC_W-1:0]  dac_o,
  output logic              sample_valid_o
);

  ctrl_s               ctrl;
  logic                mul_done;
  logic [STEP_W-1:0]   mul_a, mul_b;
  logic [2*STEP_W-1:0] mul_prod;

  adpcm_ctrl #(
    .MUL_W      (STEP_W),
    .SAMPLE_CLKS(SAMPLE_CLKS)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mul_done_i(mul_done),
    .ctrl_o    (ctrl)
  );

  adpcm_booth_mul #(.W(STEP_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ctrl.mul_start),
    .mcand_i (mul_a),
    .mplier_i(mul_b),
    .done_o  (mul_done),
    .prod_o  (mul_prod)
  );

  adpcm_datapath #(
    .ADDR_W   (ADDR_W),
    .MEM_DEPTH(MEM_DEPTH),
    .STEP_W   (STEP_W),
    .Y_W      (DAC_W),
    .STEP_INIT(STEP_INIT)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .mem_data_i(mem_data_i),
    .mul_prod_i(mul_prod),
    .mem_addr_o(mem_addr_o),
    .mul_a_o   (mul_a),
    .mul_b_o   (mul_b),
    .dac_o     (dac_o),
    .valid_o   (sample_valid_o)
  );

endmodule

// File: rtl/adpcm_dec_chk.sv
module adpcm_dec_chk #(
  parameter int ADDR_W      = 4,
  parameter int MEM_DEPTH   = 16,
  parameter int DAC_W       = 10,
  parameter int SAMPLE_CLKS = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DAC_W-1:0]  dac_o,
  input logic              sample_valid_o
);

  localparam int GW = $clog2(SAMPLE_CLKS + 1) + 1;
  localparam logic [GW-1:0] GAP_END = GW'(SAMPLE_CLKS - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(MEM_DEPTH - 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sample_valid_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  a_r7_dac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(dac_o));

  a_r2_addr_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> sample_valid_o);

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |->
      (mem_addr_o == (($past(mem_addr_o) == ADDR_LAST) ? '0 : $past(mem_addr_o) + 1'b1)));

  a_r8_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && seen_q) |-> (gap_q == GAP_END));

endmodule

bind adpcm_dec adpcm_dec_chk #(
  .ADDR_W     (ADDR_W),
  .MEM_DEPTH  (MEM_DEPTH),
  .DAC_W      (DAC_W),
  .SAMPLE_CLKS(SAMPLE_CLKS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_addr_o    (mem_addr_o),
  .dac_o         (dac_o),
  .sample_valid_o(sample_valid_o)
);

// File: tb/adpcm_dec_bench.sv
`timescale 1ns/1ps
module adpcm_dec_bench;

  localparam int ADDR_W = 4;
  localparam int DEPTH  = 16;
  localparam int PERIOD = 64;
  localparam int NSAMP  = 40;

  // stimulus bytes, high nibble decoded first
  localparam logic [7:0] ROM_BYTES [DEPTH] = '{
    8'h01, 8'h10, 8'h00, 8'h09, 8'h81,
    8'h77, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77,
    8'hFF, 8'hFF, 8'hFF, 8'h44, 8'hC5
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_data;
  logic [9:0]        dac;
  logic              valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_step, m_y, m_addr, m_nib, m_count;

  always #5 clk = ~clk;
  assign mem_data = ROM_BYTES[mem_addr];

  adpcm_dec u_adpcm_dec (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .mem_addr_o    (mem_addr),
    .mem_data_i    (mem_data),
    .dac_o         (dac),
    .sample_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int factor_of(input int mag);
    if (mag == 7) return 10;
    if (mag == 6) return 8;
    if (mag == 5) return 6;
    if (mag == 4) return 4;
    return 3;
  endfunction

  task automatic model_reset();
    m_step = 16; m_y = 0; m_addr = 0; m_nib = 0; m_count = 0;
  endtask

  task automatic model_next();
    int b, nib, mag, l, p;
    b   = ROM_BYTES[m_addr];
    nib = m_nib ? (b & 15) : (b >> 4);
    mag = nib & 7;
    m_step = (factor_of(mag) * m_step) / 4;
    if (m_step < 1) m_step = 1;
    if (m_step > 2047) m_step = 2047;
    l = (nib & 8) ? -mag : mag;
    p = m_y - (m_y >>> 3);
    m_y = p + l * m_step;
    if (m_y > 511) m_y = 511;
    if (m_y < -512) m_y = -512;
    if (m_nib) m_addr = (m_addr + 1) % DEPTH;
    m_nib = 1 - m_nib;
    m_count++;
  endtask

  task automatic wait_valid(output int gap, output bit ok);
    gap = 0; ok = 0;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk);
      gap++;
      if (valid) begin ok = 1; return; end
    end
    check(1'b0, "watchdog R8", gap, PERIOD);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    bit ok, hi_seen, lo_seen;
    logic [9:0] held;
    hi_seen = 0; lo_seen = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check(dac == 0, "R1 dac", int'(dac), 0);
    check(valid == 0, "R1 valid", int'(valid), 0);
    check(mem_addr == 0, "R1 addr", int'(mem_addr), 0);
    rst_ni = 1'b1;

    // main walk: one loop over the sample sequence
    for (int k = 0; k < NSAMP; k++) begin
      wait_valid(gap, ok);
      if (!ok) break;
      if (k > 0) check(gap + 1 == PERIOD, "R8 period", gap + 1, PERIOD);
      model_next();
      check($signed(dac) == m_y, "R6 R3 R4 R5 sample", int'($signed(dac)), m_y);
      check(int'(mem_addr) == m_addr, "R2 address", int'(mem_addr), m_addr);
      if (m_y == 511) hi_seen = 1;
      if (m_y == -512) lo_seen = 1;
      held = dac;
      @(negedge clk);
      check(!valid && dac == held, "R7 one-clock strobe", int'(valid), 0);
    end
    check(hi_seen, "R6 positive saturation reached", int'(hi_seen), 1);
    check(lo_seen, "R9 negative saturation reached", int'(lo_seen), 1);
    check(m_count >= 33, "R2 address wrapped", m_count, 33);

    // directed: reset in the middle of a sample
    repeat (17) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(dac == 0, "R1 mid-run dac", int'(dac), 0);
    check(mem_addr == 0, "R1 mid-run addr", int'(mem_addr), 0);
    rst_ni = 1'b1;
    model_reset();
    wait_valid(gap, ok);
    if (ok) begin
      model_next();
      check($signed(dac) == m_y, "R1 restart sample", int'($signed(dac)), m_y);
      check(mem_addr == 0, "R2 address held after high nibble", int'(mem_addr), 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule